// File: doc/BRIEF.md
# Indexed Address Translation Window Unit

This block keeps two banks of address translation windows, one for inbound traffic and one for outbound traffic, each holding `NUM_WIN` windows. Software reaches every window through one shared group of registers. A selector register names the bank and the window index, and the window registers that follow act on whichever window is selected. Each window has a 64-bit base, a 32-bit limit, a 64-bit target, a type field and an enable bit.

A lookup port takes a direction and a 64-bit address and answers in the same cycle. It returns a hit flag, the window type and the translated result. A memory window relocates the address into target space. A configuration window turns it into a bus number, a device/function number and a register offset inside a configuration space of `2**OFF_W` bytes. Staged register writes do not change lookups. A window's decode is captured only at the moment its second control register is written.

Top module: `atw_unit`

## Requirements
- R1: After reset every window has base 0, target 0, limit 0xFFFFFFFF and type 0 (memory). Only inbound window 0 is enabled, so an inbound address in 0..0xFFFFFFFF hits and is returned unchanged. Every outbound lookup misses.
- R2: The selector register sits at offset 0x900. Bits 3:0 are the window index and bit 31 is the bank (1 = inbound, 0 = outbound). It reads back as {bank, 27 zeros, index}.
- R3: The selected window's registers sit at these offsets: 0x904 type (bits 4:0), 0x908 enable (bit 31), 0x90C/0x910 base low/high, 0x914 limit, 0x918/0x91C target low/high. Each reads back its stored value. When the index is NUM_WIN or larger, writes to them are ignored and reads return 0.
- R4: Lookups use a snapshot of base, limit, target, type and enable that is taken when 0x908 is written. Later writes to the other window registers change the readback but not the lookup until 0x908 is written again.
- R5: A window covers the addresses from base up to and including the limit, with the limit zero-extended to 64 bits.
- R6: A memory-type hit returns target + (address − base) on lk_xlat.
- R7: Any nonzero type makes a configuration window. A hit on it sets lk_cfg. lk_bus is target bits 31:24 and lk_devfn is target bits 23:16. lk_xlat is (address − base) masked to its low OFF_W bits.
- R8: When the type is changed and 0x908 is written again, the window answers only in the new type and never in the old one.
- R9: When several enabled windows of the requested bank contain the address, the lowest index wins.
- R10: A miss returns lk_hit=0, lk_cfg=0, lk_xlat equal to the input address, and lk_bus=lk_devfn=0. A memory hit also returns zero bus and devfn.
- R11: lk_dir selects the bank that is searched (1 = inbound). Windows in the other bank have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of reg_addr |
| lk_dir | input | 1 | Lookup bank, 1 = inbound |
| lk_addr | input | 64 | Lookup address |
| lk_hit | output | 1 | Address fell in an enabled window |
| lk_cfg | output | 1 | Hit window is configuration type |
| lk_xlat | output | 64 | Translated address, config offset, or pass-through |
| lk_bus | output | 8 | Bus number on a configuration hit |
| lk_devfn | output | 8 | Device/function number on a configuration hit |

## Verification
A corrupted selector shows on the next readback cycle, or as a change to the wrong window that a later lookup exposes. A wrong captured decode shows up on the lookup port in the first cycle after the enabling write: a missing hit, a wrong relocation offset, or a configuration result where a memory result is due. A bad staged field stays hidden from lookups until the next enabling write, so the bench compares readback and lookup results across such writes to tell the staged value apart from the live one. Priority errors only appear where windows overlap, so the stimulus stacks windows on purpose.

// File: rtl/atw_pkg.sv
package atw_pkg;

    localparam int ADDR_W = 64;
    localparam int HALF_W = 32;
    localparam int KIND_W = 5;
    localparam int REG_AW = 12;
    localparam int IDX_W  = 4;

    localparam logic [REG_AW-1:0] OFS_VIEW  = 12'h900;
    localparam logic [REG_AW-1:0] OFS_CTL1  = 12'h904;
    localparam logic [REG_AW-1:0] OFS_CTL2  = 12'h908;
    localparam logic [REG_AW-1:0] OFS_BLO   = 12'h90C;
    localparam logic [REG_AW-1:0] OFS_BHI   = 12'h910;
    localparam logic [REG_AW-1:0] OFS_LIM   = 12'h914;
    localparam logic [REG_AW-1:0] OFS_TLO   = 12'h918;
    localparam logic [REG_AW-1:0] OFS_THI   = 12'h91C;

    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } atw_dir_e;

    // values software has staged for a window
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] target;
        logic [HALF_W-1:0] limit;
        logic [KIND_W-1:0] kind;
        logic              en;
    } win_cfg_t;

    // decode captured when the enable register is written
    typedef struct packed {
        logic              en;
        logic              is_cfg;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] target;
    } win_dec_t;

    typedef struct packed {
        logic              hit;
        logic              is_cfg;
        logic [ADDR_W-1:0] xlat;
        logic [7:0]        bus;
        logic [7:0]        devfn;
    } lk_res_t;

    function automatic logic in_window(input win_dec_t d, input logic [ADDR_W-1:0] a);
        return d.en && (a >= d.lo) && (a <= d.hi);
    endfunction

    function automatic logic [HALF_W-1:0] view_word(input atw_dir_e dir,
                                                   input logic [IDX_W-1:0] idx);
        return {dir, {(HALF_W-1-IDX_W){1'b0}}, idx};
    endfunction

endpackage

// File: rtl/atw_window.sv
module atw_window
    import atw_pkg::*;
#(
    parameter bit RST_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_off,
    input  logic [HALF_W-1:0] wr_data,
    output win_cfg_t          cfg,
    output win_dec_t          dec
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{base: '0, target: '0, limit: '1, kind: '0, en: RST_EN};
            dec <= '{en: RST_EN, is_cfg: 1'b0, lo: '0,
                     hi: {{HALF_W{1'b0}}, {HALF_W{1'b1}}}, target: '0};
        end else if (wr_en) begin
            case (wr_off)
                OFS_CTL1: cfg.kind <= wr_data[KIND_W-1:0];
                OFS_CTL2: begin
                    cfg.en     <= wr_data[HALF_W-1];
                    dec.en     <= wr_data[HALF_W-1];
                    dec.is_cfg <= (cfg.kind != '0);
                    dec.lo     <= cfg.base;
                    dec.hi     <= {{HALF_W{1'b0}}, cfg.limit};
                    dec.target <= cfg.target;
                end
                OFS_BLO:  cfg.base[HALF_W-1:0]        <= wr_data;
                OFS_BHI:  cfg.base[ADDR_W-1:HALF_W]   <= wr_data;
                OFS_LIM:  cfg.limit                   <= wr_data;
                OFS_TLO:  cfg.target[HALF_W-1:0]      <= wr_data;
                OFS_THI:  cfg.target[ADDR_W-1:HALF_W] <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/atw_lookup.sv
module atw_lookup
    import atw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int OFF_W   = 12
) (
    input  win_dec_t [NUM_WIN-1:0] dec,
    input  logic [ADDR_W-1:0]      addr,
    output lk_res_t                res
);

    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0] hit_vec;
    logic               found;
    logic [SEL_W-1:0]   sel;
    win_dec_t           win;
    logic [ADDR_W-1:0]  off;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        assign hit_vec[i] = in_window(dec[i], addr);
    end

    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                found = 1'b1;
                sel   = SEL_W'(i);
            end
        end
    end

    assign win = dec[sel];
    assign off = addr - win.lo;

    always_comb begin
        res = '{hit: 1'b0, is_cfg: 1'b0, xlat: addr, bus: '0, devfn: '0};
        if (found) begin
            res.hit = 1'b1;
            if (win.is_cfg) begin
                res.is_cfg = 1'b1;
                res.xlat   = {{(ADDR_W-OFF_W){1'b0}}, off[OFF_W-1:0]};
                res.bus    = win.target[31:24];
                res.devfn  = win.target[23:16];
            end else begin
                res.xlat   = win.target + off;
            end
        end
    end

endmodule

// File: rtl/atw_unit.sv
module atw_unit
    import atw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int OFF_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_dir,
    input  logic [63:0]       lk_addr,
    output logic              lk_hit,
    output logic              lk_cfg,
    output logic [63:0]       lk_xlat,
    output logic [7:0]        lk_bus,
    output logic [7:0]        lk_devfn
);

    localparam int SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [IDX_W-1:0] vp_idx;
    atw_dir_e         vp_dir;
    logic             vp_ok;

    win_cfg_t [1:0][NUM_WIN-1:0] cfg_all;
    win_dec_t [1:0][NUM_WIN-1:0] dec_all;
    win_dec_t [NUM_WIN-1:0]      dec_sel;
    win_cfg_t                    cur;
    lk_res_t                     res;

    always_ff @(posedge clk) begin
        if (rst) begin
            vp_idx <= '0;
            vp_dir <= DIR_OUT;
        end else if (reg_we && reg_addr == OFS_VIEW) begin
            vp_idx <= reg_wdata[IDX_W-1:0];
            vp_dir <= atw_dir_e'(reg_wdata[HALF_W-1]);
        end
    end

    assign vp_ok = ({1'b0, vp_idx} < (IDX_W+1)'(NUM_WIN));

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            logic wr_this;
            assign wr_this = reg_we && (vp_dir == atw_dir_e'(b)) &&
                             (vp_idx == IDX_W'(w));
            atw_window #(
                .RST_EN((b == 1 && w == 0) ? 1'b1 : 1'b0)
            ) u_win (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_this),
                .wr_off  (reg_addr),
                .wr_data (reg_wdata),
                .cfg     (cfg_all[b][w]),
                .dec     (dec_all[b][w])
            );
        end
    end

    assign dec_sel = lk_dir ? dec_all[1] : dec_all[0];

    atw_lookup #(
        .NUM_WIN (NUM_WIN),
        .OFF_W   (OFF_W)
    ) u_lookup (
        .dec  (dec_sel),
        .addr (lk_addr),
        .res  (res)
    );

    assign lk_hit   = res.hit;
    assign lk_cfg   = res.is_cfg;
    assign lk_xlat  = res.xlat;
    assign lk_bus   = res.bus;
    assign lk_devfn = res.devfn;

    assign cur = cfg_all[vp_dir][vp_idx[SEL_W-1:0]];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_VIEW) begin
            reg_rdata = view_word(vp_dir, vp_idx);
        end else if (vp_ok) begin
            case (reg_addr)
                OFS_CTL1: reg_rdata = {{(HALF_W-KIND_W){1'b0}}, cur.kind};
                OFS_CTL2: reg_rdata = {cur.en, {(HALF_W-1){1'b0}}};
                OFS_BLO:  reg_rdata = cur.base[HALF_W-1:0];
                OFS_BHI:  reg_rdata = cur.base[ADDR_W-1:HALF_W];
                OFS_LIM:  reg_rdata = cur.limit;
                OFS_TLO:  reg_rdata = cur.target[HALF_W-1:0];
                OFS_THI:  reg_rdata = cur.target[ADDR_W-1:HALF_W];
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/atw_unit_checker.sv
module atw_unit_checker
    import atw_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int OFF_W   = 12
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        reg_we,
    input logic [11:0]                 reg_addr,
    input logic [31:0]                 reg_wdata,
    input logic [63:0]                 lk_addr,
    input logic                        lk_hit,
    input logic                        lk_cfg,
    input logic [63:0]                 lk_xlat,
    input logic [7:0]                  lk_bus,
    input logic [7:0]                  lk_devfn,
    input logic [IDX_W-1:0]            vp_idx,
    input logic                        vp_dir,
    input win_dec_t [1:0][NUM_WIN-1:0] dec_all
);

    // R2: the selector captures index and bank from a write to its offset
    assert_view_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_VIEW) |=>
            (vp_idx == $past(reg_wdata[IDX_W-1:0]) && vp_dir == $past(reg_wdata[31])));

    // R4: the live decode moves only on a write to the enable register
    assert_decode_held_R4: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == OFS_CTL2) |=> $stable(dec_all));

    // R10: a miss passes the address through untouched
    assert_miss_pass_R10: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_xlat == lk_addr && !lk_cfg));

    // R10: bus and devfn stay zero unless a configuration window hit
    assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !(lk_hit && lk_cfg) |-> (lk_bus == 8'h00 && lk_devfn == 8'h00));

    // R7: a configuration offset never leaves the configuration space
    assert_cfg_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_cfg) |-> (lk_xlat < (64'd1 << OFF_W)));

endmodule

bind atw_unit atw_unit_checker #(
    .NUM_WIN (NUM_WIN),
    .OFF_W   (OFF_W)
) u_atw_unit_checker (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_cfg    (lk_cfg),
    .lk_xlat   (lk_xlat),
    .lk_bus    (lk_bus),
    .lk_devfn  (lk_devfn),
    .vp_idx    (vp_idx),
    .vp_dir    (vp_dir),
    .dec_all   (dec_all)
);

// File: tb/atw_unit_bench.sv
module atw_unit_bench;

    localparam logic [11:0] A_VIEW = 12'h900;
    localparam logic [11:0] A_CTL1 = 12'h904;
    localparam logic [11:0] A_CTL2 = 12'h908;
    localparam logic [11:0] A_BLO  = 12'h90C;
    localparam logic [11:0] A_BHI  = 12'h910;
    localparam logic [11:0] A_LIM  = 12'h914;
    localparam logic [11:0] A_TLO  = 12'h918;
    localparam logic [11:0] A_THI  = 12'h91C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_dir = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        lk_hit, lk_cfg;
    logic [63:0] lk_xlat;
    logic [7:0]  lk_bus, lk_devfn;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    atw_unit u_atw_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_dir(lk_dir),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_cfg(lk_cfg), .lk_xlat(lk_xlat),
        .lk_bus(lk_bus), .lk_devfn(lk_devfn)
    );

    typedef struct packed {
        logic        dir;
        logic [63:0] addr;
        logic        hit;
        logic        cfg;
        logic [63:0] xlat;
        logic [7:0]  bus;
        logic [7:0]  dvf;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h0000_0000_1000_0000, 1'b1, 1'b0, 64'h0000_0002_0000_0000, 8'h00, 8'h00}, // R5 R6 low edge
        '{1'b0, 64'h0000_0000_1000_FFFF, 1'b1, 1'b0, 64'h0000_0002_0000_FFFF, 8'h00, 8'h00}, // R5 high edge
        '{1'b0, 64'h0000_0000_1001_0000, 1'b0, 1'b0, 64'h0000_0000_1001_0000, 8'h00, 8'h00}, // R5 R10 past limit
        '{1'b0, 64'h0000_0000_0FFF_FFFF, 1'b0, 1'b0, 64'h0000_0000_0FFF_FFFF, 8'h00, 8'h00}, // R10 below base
        '{1'b0, 64'h0000_0000_1000_8010, 1'b1, 1'b0, 64'h0000_0000_5000_0010, 8'h00, 8'h00}, // R9 window 0 wins
        '{1'b0, 64'h0000_0000_1000_9000, 1'b1, 1'b0, 64'h0000_0002_0000_9000, 8'h00, 8'h00}, // R9 only window 1
        '{1'b0, 64'h0000_0000_2000_0ABC, 1'b1, 1'b1, 64'h0000_0000_0000_0ABC, 8'h01, 8'h12}, // R7
        '{1'b0, 64'h0000_0000_2000_1ABC, 1'b1, 1'b1, 64'h0000_0000_0000_0ABC, 8'h01, 8'h12}, // R7 offset masked
        '{1'b1, 64'h0000_0000_1000_0000, 1'b1, 1'b0, 64'h0000_0000_1000_0000, 8'h00, 8'h00}, // R11 inbound default
        '{1'b1, 64'h0000_0002_0000_0000, 1'b0, 1'b0, 64'h0000_0002_0000_0000, 8'h00, 8'h00}, // R11 inbound miss
        '{1'b0, 64'h0000_0001_1000_0000, 1'b0, 1'b0, 64'h0000_0001_1000_0000, 8'h00, 8'h00}  // R5 zero-extended limit
    };

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: reg %h read %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic lk_chk(input logic d, input logic [63:0] a, input logic eh, input logic ec,
                          input logic [63:0] ex, input logic [7:0] eb, input logic [7:0] ed,
                          input string tag);
        @(negedge clk);
        lk_dir = d; lk_addr = a;
        #1;
        total++;
        if (lk_hit !== eh || lk_cfg !== ec || lk_xlat !== ex || lk_bus !== eb || lk_devfn !== ed) begin
            bad++;
            $display("FAIL %s: addr %h got hit=%b cfg=%b xlat=%h bus=%h devfn=%h expected hit=%b cfg=%b xlat=%h bus=%h devfn=%h",
                     tag, a, lk_hit, lk_cfg, lk_xlat, lk_bus, lk_devfn, eh, ec, ex, eb, ed);
        end
    endtask

    task automatic pick(input logic d, input logic [3:0] idx);
        wr(A_VIEW, {d, 27'b0, idx});
    endtask

    task automatic prog(input logic d, input logic [3:0] idx, input logic [63:0] base,
                        input logic [31:0] lim, input logic [63:0] tgt, input logic [4:0] kind);
        pick(d, idx);
        wr(A_BLO, base[31:0]);
        wr(A_BHI, base[63:32]);
        wr(A_LIM, lim);
        wr(A_TLO, tgt[31:0]);
        wr(A_THI, tgt[63:32]);
        wr(A_CTL1, {27'b0, kind});
        wr(A_CTL2, 32'h8000_0000);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        lk_chk(1'b1, 64'h1234, 1'b1, 1'b0, 64'h1234, 8'h00, 8'h00, "R1 inbound default window");
        lk_chk(1'b1, 64'hFFFF_FFFF, 1'b1, 1'b0, 64'hFFFF_FFFF, 8'h00, 8'h00, "R1 inbound top of default");
        lk_chk(1'b0, 64'h1234, 1'b0, 1'b0, 64'h1234, 8'h00, 8'h00, "R1 outbound misses");
        rd_chk(A_VIEW, 32'h0, "R1 selector reset");
        rd_chk(A_LIM, 32'hFFFF_FFFF, "R1 limit reset");
        rd_chk(A_CTL2, 32'h0, "R1 outbound window 0 disabled");
        pick(1'b1, 4'd0);
        rd_chk(A_CTL2, 32'h8000_0000, "R1 inbound window 0 enabled");

        // programme outbound windows
        prog(1'b0, 4'd1, 64'h1000_0000, 32'h1000_FFFF, 64'h2_0000_0000, 5'd0);
        prog(1'b0, 4'd2, 64'h2000_0000, 32'h2000_FFFF, 64'h0112_0000, 5'd4);
        prog(1'b0, 4'd0, 64'h1000_8000, 32'h1000_8FFF, 64'h5000_0000, 5'd0);

        // R3 readback of window 2
        pick(1'b0, 4'd2);
        rd_chk(A_CTL1, 32'd4, "R3 type readback");
        rd_chk(A_CTL2, 32'h8000_0000, "R3 enable readback");
        rd_chk(A_BLO, 32'h2000_0000, "R3 base low readback");
        rd_chk(A_TLO, 32'h0112_0000, "R3 target low readback");
        pick(1'b0, 4'd1);
        rd_chk(A_THI, 32'h2, "R3 target high readback");

        // table walk: R5 R6 R7 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            lk_chk(VECS[i].dir, VECS[i].addr, VECS[i].hit, VECS[i].cfg, VECS[i].xlat,
                   VECS[i].bus, VECS[i].dvf, $sformatf("R5/R6/R7/R9/R10/R11 vector %0d", i));
        end

        // R2 selector field packing, unused bits dropped
        wr(A_VIEW, 32'hFFFF_FFF3);
        rd_chk(A_VIEW, 32'h8000_0003, "R2 selector readback");

        // R3 out-of-range index ignored
        pick(1'b0, 4'd5);
        rd_chk(A_VIEW, 32'h0000_0005, "R2 selector index 5");
        wr(A_BLO, 32'h1000_0000);
        wr(A_LIM, 32'h3FFF_FFFF);
        wr(A_CTL2, 32'h8000_0000);
        rd_chk(A_BLO, 32'h0, "R3 out-of-range read is zero");
        lk_chk(1'b0, 64'h3000_0000, 1'b0, 1'b0, 64'h3000_0000, 8'h00, 8'h00, "R3 out-of-range write ignored");
        lk_chk(1'b0, 64'h1000_0000, 1'b1, 1'b0, 64'h2_0000_0000, 8'h00, 8'h00, "R3 real windows untouched");

        // R4 staged writes do not move the live decode
        pick(1'b0, 4'd1);
        wr(A_BLO, 32'h3000_0000);
        wr(A_LIM, 32'h3000_00FF);
        rd_chk(A_BLO, 32'h3000_0000, "R4 staged base visible");
        lk_chk(1'b0, 64'h1000_0000, 1'b1, 1'b0, 64'h2_0000_0000, 8'h00, 8'h00, "R4 old decode still live");
        lk_chk(1'b0, 64'h3000_0010, 1'b0, 1'b0, 64'h3000_0010, 8'h00, 8'h00, "R4 new range not live yet");
        wr(A_CTL2, 32'h8000_0000);
        lk_chk(1'b0, 64'h3000_0010, 1'b1, 1'b0, 64'h2_0000_0010, 8'h00, 8'h00, "R4 new range live");
        lk_chk(1'b0, 64'h1000_0000, 1'b0, 1'b0, 64'h1000_0000, 8'h00, 8'h00, "R4 old range gone");

        // R8 type switch
        wr(A_CTL1, 32'd7);
        lk_chk(1'b0, 64'h3000_0010, 1'b1, 1'b0, 64'h2_0000_0010, 8'h00, 8'h00, "R8 type staged only");
        wr(A_CTL2, 32'h8000_0000);
        lk_chk(1'b0, 64'h3000_0010, 1'b1, 1'b1, 64'h10, 8'h00, 8'h00, "R8 now configuration");
        wr(A_CTL1, 32'd0);
        wr(A_CTL2, 32'h8000_0000);
        lk_chk(1'b0, 64'h3000_0010, 1'b1, 1'b0, 64'h2_0000_0010, 8'h00, 8'h00, "R8 back to memory");

        // R4 disable through enable register
        wr(A_CTL2, 32'h0);
        lk_chk(1'b0, 64'h3000_0010, 1'b0, 1'b0, 64'h3000_0010, 8'h00, 8'h00, "R4 disabled window misses");

        // R11 inbound bank independent of outbound programming
        lk_chk(1'b1, 64'h2000_0ABC, 1'b1, 1'b0, 64'h2000_0ABC, 8'h00, 8'h00, "R11 inbound ignores outbound cfg");

        // R1 reset again restores defaults
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        lk_chk(1'b0, 64'h2000_0ABC, 1'b0, 1'b0, 64'h2000_0ABC, 8'h00, 8'h00, "R1 reset clears outbound");

        summary();
        $finish;
    end

endmodule